// File: doc/BRIEF.md
# SPI chip-select expander

This block widens the select fan-out of an SPI host that has only two select lines of its own. It turns them into up to eight active-low device selects. The host loads the wanted select pattern over the SPI bus itself. While the expander's latch line is low, the pattern is clocked in from MOSI on each rising SCLK edge. Raising the latch line copies the shift register into a parallel latch. The second host line is an active-low output enable: while it is high, every device select is driven high, exactly as a pull-up network would leave them. All inputs are oversampled by the block's own clock through a synchronizer chain, so the selects change only on that clock.

A mode pin turns the block into a small decoder instead. The two host lines then form a 2-bit code that selects one of three devices, and the fourth code selects nothing. A latched pattern with more than one zero is refused: the selects stay high and an error flag is raised until a valid pattern is latched. The controller has four states. ST_OFF means expander mode with the outputs disabled. ST_ON means expander mode driving the latched pattern. ST_FAULT means the latched pattern is invalid. ST_DECODE means decoder mode. From every state the controller moves to ST_DECODE when the mode pin is high. When the mode pin is low it moves to ST_FAULT if the latched pattern is invalid. Otherwise it moves to ST_ON if the enable is low and to ST_OFF if the enable is high.

Top module: `csx_select_expander`

## Requirements
- R1: After reset, all device selects are high, the error flag is low, and the latch holds all ones, so enabling the outputs with no pattern loaded still leaves every select high.
- R2: On each rising SCLK edge the MOSI bit is shifted in MSB first. A rising edge on the latch line copies the last NSEL bits into the latch, and the first bit of a byte drives dev_sel_n[7].
- R3: Shifting with the latch line held high has no effect on the device selects.
- R4: While host_sel_oe_n is high, all device selects are high. The latched pattern is retained, and it reappears when host_sel_oe_n returns low.
- R5: At most one device select is ever low. A latched pattern with two or more zeros raises pattern_err and forces all selects high. The all-ones pattern is valid and selects nothing. latching a valid pattern clears the error.
- R6: With decode_mode high, the code {host_sel_oe_n, host_sel_latch} gives the following: 00 drives select 0 low, 01 drives select 1 low, 10 drives select 2 low, and 11 drives none low. Selects 3 and up stay high and pattern_err is low.
- R7: A change on host_sel_oe_n, decode_mode or the decode code reaches the outputs on the SYNC_STAGES+2'th clock edge. A rising latch edge reaches them on the SYNC_STAGES+3'th edge.
- R8: When more than NSEL bits are shifted before a latch edge, only the last NSEL bits are used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that oversamples every SPI-side input |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | SPI serial clock; rising edges shift the select register |
| spi_mosi | input | 1 | SPI data feeding the select shift register |
| host_sel_latch | input | 1 | Host select A; a rising edge latches the pattern; code bit 0 in decoder mode |
| host_sel_oe_n | input | 1 | Host select B; active-low output enable; code bit 1 in decoder mode |
| decode_mode | input | 1 | 1 selects the three-way decoder, 0 the serial-loaded expander |
| dev_sel_n | output | NSEL | Active-low device selects |
| pattern_err | output | 1 | High while the latched pattern has more than one zero (expander mode) |

## Verification
The outputs lag every input by a fixed number of block clocks. An enable, mode or code change passes through the synchronizer and the state register to the output register, so it is due on edge SYNC_STAGES+2. A latch strobe adds the latch register, so it is due on edge SYNC_STAGES+3. The bench drives inputs on falling edges and samples on falling edges. For the timing checks it samples once, one edge before the due edge, to show the old value is still present, and then once right after the due edge. Every other check waits a settle interval well beyond the longest latency, and each SCLK level is held for several block clocks, so no sample falls within a transition.

// File: rtl/csx_pkg.sv
package csx_pkg;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_ON     = 2'd1,
        ST_FAULT  = 2'd2,
        ST_DECODE = 2'd3
    } csx_state_e;

    // Number of live outputs of the two-line decoder; code 11 drives none.
    localparam int DEC_OUTS = 3;
    localparam int CODE_W   = 2;

endpackage

// File: rtl/csx_sync.sv
module csx_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/csx_shift.sv
module csx_shift #(
    parameter int NSEL = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk_s,
    input  logic            mosi_s,
    input  logic            strobe_s,
    output logic [NSEL-1:0] latch_q
);

    logic            sclk_p;
    logic            strobe_p;
    logic [NSEL-1:0] shreg;
    logic            sclk_rise;
    logic            strobe_rise;

    assign sclk_rise   = sclk_s & ~sclk_p;
    assign strobe_rise = strobe_s & ~strobe_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_p   <= 1'b0;
            strobe_p <= 1'b1;
            shreg    <= '1;
            latch_q  <= '1;
        end else begin
            sclk_p   <= sclk_s;
            strobe_p <= strobe_s;
            if (sclk_rise) shreg <= {shreg[NSEL-2:0], mosi_s};
            if (strobe_rise) latch_q <= shreg;
        end
    end

    // R2: a sampled SCLK rise places the sampled MOSI bit at the bottom
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_s && !sclk_p) |=> (shreg[0] == $past(mosi_s)));

    // R2: the latch takes the shift register contents on a strobe rise
    assert_latch_copy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_s && !strobe_p) |=> (latch_q == $past(shreg)));

    // R3: without a strobe rise the latch keeps its value
    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe_s && !strobe_p) |=> $stable(latch_q));

endmodule

// File: rtl/csx_ctrl.sv
module csx_ctrl
    import csx_pkg::*;
#(
    parameter int NSEL = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_s,
    input  logic              oe_n_s,
    input  logic [CODE_W-1:0] code_s,
    input  logic [NSEL-1:0]   latch_q,
    output logic [NSEL-1:0]   dev_sel_n,
    output logic              err
);

    csx_state_e          state_q, state_d, exp_target;
    logic [NSEL-1:0]     pat_q;
    logic [CODE_W-1:0]   code_q;
    logic [NSEL-1:0]     dec_vec;
    logic                pat_ok;

    assign pat_ok = ($countones(~latch_q) <= 1);

    always_comb begin
        if (!pat_ok)      exp_target = ST_FAULT;
        else if (!oe_n_s) exp_target = ST_ON;
        else              exp_target = ST_OFF;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:    state_d = mode_s ? ST_DECODE : exp_target;
            ST_ON:     state_d = mode_s ? ST_DECODE : exp_target;
            ST_FAULT:  state_d = mode_s ? ST_DECODE : exp_target;
            ST_DECODE: state_d = mode_s ? ST_DECODE : exp_target;
        endcase
    end

    // State register with the pattern and code that belong to the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            pat_q   <= '1;
            code_q  <= '1;
        end else begin
            state_q <= state_d;
            pat_q   <= latch_q;
            code_q  <= code_s;
        end
    end

    generate
        for (genvar g = 0; g < NSEL; g++) begin : g_dec
            if (g < DEC_OUTS) begin : g_live
                assign dec_vec[g] = (code_q != CODE_W'(g));
            end else begin : g_idle
                assign dec_vec[g] = 1'b1;
            end
        end
    endgenerate

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dev_sel_n <= '1;
            err       <= 1'b0;
        end else begin
            unique case (state_q)
                ST_OFF: begin
                    dev_sel_n <= '1;
                    err       <= 1'b0;
                end
                ST_ON: begin
                    dev_sel_n <= pat_q;
                    err       <= 1'b0;
                end
                ST_FAULT: begin
                    dev_sel_n <= '1;
                    err       <= 1'b1;
                end
                ST_DECODE: begin
                    dev_sel_n <= dec_vec;
                    err       <= 1'b0;
                end
            endcase
        end
    end

    // R5: never more than one select low
    assert_one_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~dev_sel_n) <= 1));

    // R4: disabled state releases every select
    assert_off_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OFF) |=> (&dev_sel_n && !err));

    // R5: fault state raises the flag with selects high
    assert_fault_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAULT) |=> (&dev_sel_n && err));

    // R6: code 11 in decoder mode selects nothing
    assert_decode_none_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE && code_q == 2'b11) |=> &dev_sel_n);

    // R6: upper selects stay high in decoder mode
    assert_decode_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DECODE) |=> (&dev_sel_n[NSEL-1:DEC_OUTS] && !err));

endmodule

// File: rtl/csx_select_expander.sv
module csx_select_expander
    import csx_pkg::*;
#(
    parameter int NSEL        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spi_sclk,
    input  logic            spi_mosi,
    input  logic            host_sel_latch,
    input  logic            host_sel_oe_n,
    input  logic            decode_mode,
    output logic [NSEL-1:0] dev_sel_n,
    output logic            pattern_err
);

    localparam int IN_W = 5;
    // {mode, oe_n, latch, mosi, sclk} at their idle values
    localparam logic [IN_W-1:0] IN_IDLE = 5'b01100;

    logic [IN_W-1:0]   raw_in, sync_in;
    logic              sclk_s, mosi_s, latch_s, oe_n_s, mode_s;
    logic [NSEL-1:0]   latch_q;
    logic [CODE_W-1:0] code_s;

    assign raw_in = {decode_mode, host_sel_oe_n, host_sel_latch, spi_mosi, spi_sclk};

    csx_sync #(
        .W       (IN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (IN_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    assign {mode_s, oe_n_s, latch_s, mosi_s, sclk_s} = sync_in;
    assign code_s = {oe_n_s, latch_s};

    csx_shift #(
        .NSEL (NSEL)
    ) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .mosi_s   (mosi_s),
        .strobe_s (latch_s),
        .latch_q  (latch_q)
    );

    csx_ctrl #(
        .NSEL (NSEL)
    ) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_s    (mode_s),
        .oe_n_s    (oe_n_s),
        .code_s    (code_s),
        .latch_q   (latch_q),
        .dev_sel_n (dev_sel_n),
        .err       (pattern_err)
    );

endmodule

// File: tb/test_csx_select_expander.sv
module test_csx_select_expander;

    localparam int CLK_PERIOD = 10;
    localparam int SYNC       = 2;
    localparam int HALF       = 4;
    localparam int SETTLE     = 12;
    localparam int NVEC       = 8;

    // {pattern, enable, expected selects, expected error}
    localparam logic [17:0] VEC [NVEC] = '{
        {8'hFE, 1'b1, 8'hFE, 1'b0},
        {8'h7F, 1'b1, 8'h7F, 1'b0},
        {8'hFF, 1'b1, 8'hFF, 1'b0},
        {8'hEF, 1'b0, 8'hFF, 1'b0},
        {8'hF3, 1'b1, 8'hFF, 1'b1},
        {8'h00, 1'b0, 8'hFF, 1'b1},
        {8'hBF, 1'b1, 8'hBF, 1'b0},
        {8'hFB, 1'b1, 8'hFB, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       host_sel_latch = 1'b1;
    logic       host_sel_oe_n = 1'b1;
    logic       decode_mode = 1'b0;
    logic [7:0] dev_sel_n;
    logic       pattern_err;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csx_select_expander #(.NSEL(8), .SYNC_STAGES(SYNC)) i_csx_select_expander (
        .clk            (clk),
        .rst_n          (rst_n),
        .spi_sclk       (spi_sclk),
        .spi_mosi       (spi_mosi),
        .host_sel_latch (host_sel_latch),
        .host_sel_oe_n  (host_sel_oe_n),
        .decode_mode    (decode_mode),
        .dev_sel_n      (dev_sel_n),
        .pattern_err    (pattern_err)
    );

    task automatic check(input string req, input logic [7:0] exp_sel, input logic exp_err);
        n_checks++;
        if (dev_sel_n !== exp_sel || pattern_err !== exp_err) begin
            n_errors++;
            $display("FAIL %s: sel=%h err=%b expected sel=%h err=%b",
                     req, dev_sel_n, pattern_err, exp_sel, exp_err);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Shift the low n bits of v, highest first, without touching the latch line
    task automatic shift_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            spi_mosi = v[i];
            wait_neg(HALF);
            spi_sclk = 1'b1;
            wait_neg(HALF);
            spi_sclk = 1'b0;
        end
        wait_neg(HALF);
    endtask

    task automatic load_byte(input logic [7:0] b);
        host_sel_latch = 1'b0;
        wait_neg(HALF);
        shift_bits({8'h00, b}, 8);
        host_sel_latch = 1'b1;
        wait_neg(SETTLE);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog R7: run actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        wait_neg(5);
        rst_n = 1'b1;
        wait_neg(3);
        check("R1 reset state", 8'hFF, 1'b0);
        host_sel_oe_n = 1'b0;
        wait_neg(SETTLE);
        check("R1 enabled with reset latch", 8'hFF, 1'b0);

        // Table walk: R2 mapping, R4 enable, R5 validity
        for (int k = 0; k < NVEC; k++) begin
            load_byte(VEC[k][17:10]);
            host_sel_oe_n = ~VEC[k][9];
            wait_neg(SETTLE);
            check($sformatf("R2/R4/R5 vector %0d", k), VEC[k][8:1], VEC[k][0]);
        end

        // R3: shifting with the latch line high changes nothing
        load_byte(8'hFE);
        check("R2 pattern FE", 8'hFE, 1'b0);
        shift_bits(16'h007F, 8);
        wait_neg(SETTLE);
        check("R3 shift without strobe ignored", 8'hFE, 1'b0);

        // R8: twelve bits, only the last eight count
        host_sel_latch = 1'b0;
        wait_neg(HALF);
        shift_bits(16'h00FD, 12);
        host_sel_latch = 1'b1;
        wait_neg(SETTLE);
        check("R8 last eight bits latched", 8'hFD, 1'b0);

        // R4: disable then re-enable keeps the pattern
        host_sel_oe_n = 1'b1;
        wait_neg(SETTLE);
        check("R4 disabled all high", 8'hFF, 1'b0);

        // R7: enable latency SYNC+2 edges, R4 pattern retained
        host_sel_oe_n = 1'b0;
        wait_neg(SYNC + 1);
        check("R7 enable not yet visible", 8'hFF, 1'b0);
        wait_neg(1);
        check("R7 enable visible on time (R4 retained)", 8'hFD, 1'b0);

        // R7: latch latency SYNC+3 edges
        host_sel_latch = 1'b0;
        wait_neg(HALF);
        shift_bits(16'h007F, 8);
        wait_neg(SETTLE);
        check("R3 low latch line alone no effect", 8'hFD, 1'b0);
        host_sel_latch = 1'b1;
        wait_neg(SYNC + 2);
        check("R7 latch not yet visible", 8'hFD, 1'b0);
        wait_neg(1);
        check("R7 latch visible on time", 8'h7F, 1'b0);

        // R6: decoder mode
        decode_mode = 1'b1;
        host_sel_oe_n = 1'b0;
        host_sel_latch = 1'b0;
        wait_neg(SETTLE);
        check("R6 code 00", 8'hFE, 1'b0);
        host_sel_latch = 1'b1;
        wait_neg(SETTLE);
        check("R6 code 01", 8'hFD, 1'b0);
        host_sel_oe_n = 1'b1;
        host_sel_latch = 1'b0;
        wait_neg(SETTLE);
        check("R6 code 10", 8'hFB, 1'b0);
        host_sel_latch = 1'b1;
        wait_neg(SETTLE);
        check("R6 code 11 none", 8'hFF, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule